// File: doc/BRIEF.md
# Branch Direction Predictor with Selectable Policies

This block guesses whether a conditional branch will be taken. Each cycle a fetch stage may present a request made of the branch address and its opcode, together with a policy selector. One cycle later the block returns a registered valid flag and a taken/not-taken guess. When the branch later resolves, the execute stage reports the address and the real outcome on a separate update port. The block uses that report to train its tables.

There are five policies: never taken, always taken, a static guess looked up per opcode, a one-bit table holding the last outcome of each branch, and a table of saturating history counters. The policy is chosen per request, so the same trace can be replayed under each policy for comparison. The two dynamic tables have no tags and are indexed by the low address bits. A small configuration write port loads the per-opcode static bits.

Top module: `bdp_core`

## Requirements
- R1: When a request carries policy code 0, the guess returned one cycle later is not taken.
- R2: When a request carries policy code 1, the guess returned one cycle later is taken.
- R3: With policy code 2, the guess is the static bit stored for the request opcode. The configuration port writes that bit (cfg_bit_i into entry cfg_op_i when cfg_we_i is high). All static bits are 0 after reset, and updates never change them.
- R4: With policy code 3, the guess is the outcome of the most recent update to the same table entry.
- R5: With policy code 4, each entry holds a 2-bit saturating counter. A taken update raises it (stopping at 3) and a not-taken update lowers it (stopping at 0). The guess is taken when the counter is 2 or 3.
- R6: After reset, every one-bit entry holds not taken and every counter holds 1, so the first guesses in both dynamic policies are not taken.
- R7: Table entries are selected by address bits [IDX_W-1:0] (bits [5:0] by default) with no tag. Two addresses that agree in those bits share one entry.
- R8: If an update and a request touch the same entry, or a configuration write and a request touch the same opcode, in one cycle, the request sees the value from before that cycle.
- R9: pred_valid_o is high exactly in the cycle after a cycle with req_valid_i high, and is low during and right after reset. Policy codes 5 to 7 guess not taken.
- R10: Every update trains both dynamic tables, whatever policy the requests in flight use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 3 | Policy code sent with the request |
| req_valid_i | input | 1 | A prediction request is present |
| req_pc_i | input | PC_W | Branch address of the request |
| req_op_i | input | OP_W | Branch opcode of the request |
| pred_valid_o | output | 1 | Guess valid, one cycle after the request |
| pred_taken_o | output | 1 | Guess: 1 taken, 0 not taken |
| upd_valid_i | input | 1 | A resolved outcome is present |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| cfg_we_i | input | 1 | Write strobe for a static opcode bit |
| cfg_op_i | input | OP_W | Opcode whose static bit is written |
| cfg_bit_i | input | 1 | Static bit value |

## Verification
The bench runs counters across both saturation limits and steps them back through the threshold. A counter that wraps instead of saturating would flip its guess after the fourth taken outcome, and one that is compared against the wrong threshold would break the weakly-taken and weakly-not-taken steps. It presents an update and a request for the same entry in the same cycle. A design that forwards the new value would return the trained outcome one request too early. It trains an entry with one address and reads it back through an alias that differs only above the index bits, which catches a design that indexes with the wrong bits. It trains the tables while requests use the static policies and loads opcode bits while the dynamic tables change, which catches a design that gates training by policy or lets updates reach the opcode bits.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef enum logic [2:0] {
    POL_NEVER  = 3'd0,
    POL_ALWAYS = 3'd1,
    POL_OPCODE = 3'd2,
    POL_LAST   = 3'd3,
    POL_HIST   = 3'd4
  } pol_e;

endpackage

// File: rtl/bdp_rst_sync.sv
module bdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bdp_last_tbl.sv
module bdp_last_tbl #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] bit_q;
  logic [ENTRIES-1:0] bit_d;
  logic [ENTRIES-1:0] bit_en;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      bit_en[e] = wr_en && (wr_idx == IDX_W'(e));
      bit_d[e]  = wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q[e] <= 1'b0;
      else if (bit_en[e])  bit_q[e] <= bit_d[e];
    end
  end

  assign rd_bit = bit_q[rd_idx];

endmodule

// File: rtl/bdp_ctr_tbl.sv
module bdp_ctr_tbl #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int             ENTRIES  = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W-1)) - 1);

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [CTR_W-1:0] ctr_d [ENTRIES];
  logic             ctr_en [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      ctr_en[e] = wr_en && (wr_idx == IDX_W'(e));
      ctr_d[e]  = ctr_q[e];
      if (wr_taken) begin
        if (ctr_q[e] != CTR_MAX) ctr_d[e] = ctr_q[e] + 1'b1;
      end else begin
        if (ctr_q[e] != CTR_MIN) ctr_d[e] = ctr_q[e] - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctr_q[e] <= CTR_INIT;
      else if (ctr_en[e])  ctr_q[e] <= ctr_d[e];
    end
  end

  logic [CTR_W-1:0] rd_ctr;
  assign rd_ctr   = ctr_q[rd_idx];
  assign rd_taken = rd_ctr[CTR_W-1];

endmodule

// File: rtl/bdp_opc_tbl.sv
module bdp_opc_tbl #(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] rd_op,
  output logic            rd_bit,
  input  logic            wr_en,
  input  logic [OP_W-1:0] wr_op,
  input  logic            wr_bit
);

  localparam int CODES = 1 << OP_W;

  logic [CODES-1:0] sb_q;
  logic [CODES-1:0] sb_d;
  logic [CODES-1:0] sb_en;

  for (genvar c = 0; c < CODES; c++) begin : g_code
    always_comb begin
      sb_en[c] = wr_en && (wr_op == OP_W'(c));
      sb_d[c]  = wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sb_q[c] <= 1'b0;
      else if (sb_en[c])  sb_q[c] <= sb_d[c];
    end
  end

  assign rd_bit = sb_q[rd_op];

endmodule

// File: rtl/bdp_core.sv
module bdp_core
  import bdp_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int OP_W  = 4,
  parameter int CTR_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      mode_i,
  input  logic            req_valid_i,
  input  logic [PC_W-1:0] req_pc_i,
  input  logic [OP_W-1:0] req_op_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            cfg_we_i,
  input  logic [OP_W-1:0] cfg_op_i,
  input  logic            cfg_bit_i
);

  logic rst_n_s;

  bdp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             unused_pc_hi;

  assign rd_idx       = req_pc_i[IDX_W-1:0];
  assign wr_idx       = upd_pc_i[IDX_W-1:0];
  assign unused_pc_hi = ^{req_pc_i[PC_W-1:IDX_W], upd_pc_i[PC_W-1:IDX_W]};

  logic last_bit;
  logic hist_taken;
  logic opc_bit;

  bdp_last_tbl #(.IDX_W(IDX_W)) u_last (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rd_idx (rd_idx),
    .rd_bit (last_bit),
    .wr_en  (upd_valid_i),
    .wr_idx (wr_idx),
    .wr_bit (upd_taken_i)
  );

  bdp_ctr_tbl #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_idx   (rd_idx),
    .rd_taken (hist_taken),
    .wr_en    (upd_valid_i),
    .wr_idx   (wr_idx),
    .wr_taken (upd_taken_i)
  );

  bdp_opc_tbl #(.OP_W(OP_W)) u_opc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .rd_op  (req_op_i),
    .rd_bit (opc_bit),
    .wr_en  (cfg_we_i),
    .wr_op  (cfg_op_i),
    .wr_bit (cfg_bit_i)
  );

  logic guess;

  always_comb begin
    unique case (mode_i)
      POL_NEVER:  guess = 1'b0;
      POL_ALWAYS: guess = 1'b1;
      POL_OPCODE: guess = opc_bit;
      POL_LAST:   guess = last_bit;
      POL_HIST:   guess = hist_taken;
      default:    guess = 1'b0;
    endcase
  end

  logic pv_q, pv_d;
  logic pt_q, pt_d;

  always_comb begin
    pv_d = req_valid_i;
    pt_d = req_valid_i ? guess : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pv_q <= 1'b0;
      pt_q <= 1'b0;
    end else begin
      pv_q <= pv_d;
      pt_q <= pt_d;
    end
  end

  assign pred_valid_o = pv_q;
  assign pred_taken_o = pt_q;

endmodule

// File: rtl/bdp_core_chk.sv
module bdp_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       req_valid_i,
  input logic       pred_valid_o,
  input logic       pred_taken_o
);

  // R1
  assert_never_nt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 3'd0) |=> (pred_valid_o && !pred_taken_o));

  // R2
  assert_always_t_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i == 3'd1) |=> (pred_valid_o && pred_taken_o));

  // R9
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> pred_valid_o);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !pred_valid_o);

  assert_spare_codes_nt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && mode_i > 3'd4) |=> !pred_taken_o);

  always_comb begin
    if (rst_n && !pred_valid_o) begin
      assert_idle_low_R9: assert (!pred_taken_o);
    end
  end

endmodule

bind bdp_core bdp_core_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .req_valid_i  (req_valid_i),
  .pred_valid_o (pred_valid_o),
  .pred_taken_o (pred_taken_o)
);

// File: tb/bdp_core_tb.sv
`timescale 1ns/1ps
module bdp_core_tb;

  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam int OP_W  = 4;
  localparam int ENT   = 1 << IDX_W;
  localparam int CODES = 1 << OP_W;

  logic            clk;
  logic            rst_n;
  logic [2:0]      mode_i;
  logic            req_valid_i;
  logic [PC_W-1:0] req_pc_i;
  logic [OP_W-1:0] req_op_i;
  logic            pred_valid_o;
  logic            pred_taken_o;
  logic            upd_valid_i;
  logic [PC_W-1:0] upd_pc_i;
  logic            upd_taken_i;
  logic            cfg_we_i;
  logic [OP_W-1:0] cfg_op_i;
  logic            cfg_bit_i;

  bdp_core #(.PC_W(PC_W), .IDX_W(IDX_W), .OP_W(OP_W), .CTR_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_valid_i(req_valid_i),
    .req_pc_i(req_pc_i), .req_op_i(req_op_i), .pred_valid_o(pred_valid_o),
    .pred_taken_o(pred_taken_o), .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i),
    .upd_taken_i(upd_taken_i), .cfg_we_i(cfg_we_i), .cfg_op_i(cfg_op_i),
    .cfg_bit_i(cfg_bit_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  // reference model state
  logic       m_last [ENT];
  int         m_ctr  [ENT];
  logic       m_opc  [CODES];

  // scoreboard
  logic  exp_v_q [$];
  logic  exp_t_q [$];
  string tag_q   [$];

  function automatic logic model_guess(input logic [2:0] md, input logic [PC_W-1:0] pc,
                                       input logic [OP_W-1:0] op);
    int ix;
    ix = int'(pc[IDX_W-1:0]);
    case (md)
      3'd1:    return 1'b1;
      3'd2:    return m_opc[op];
      3'd3:    return m_last[ix];
      3'd4:    return (m_ctr[ix] >= 2);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic rv, input logic [2:0] md, input logic [PC_W-1:0] pc,
                      input logic [OP_W-1:0] op, input logic uv, input logic [PC_W-1:0] upc,
                      input logic ut, input logic cw, input logic [OP_W-1:0] cop,
                      input logic cb, input string tag);
    int ux;
    @(negedge clk);
    req_valid_i = rv; mode_i = md; req_pc_i = pc; req_op_i = op;
    upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    cfg_we_i = cw; cfg_op_i = cop; cfg_bit_i = cb;
    exp_v_q.push_back(rv);
    exp_t_q.push_back(rv ? model_guess(md, pc, op) : 1'b0);
    tag_q.push_back(tag);
    if (uv) begin
      ux = int'(upc[IDX_W-1:0]);
      m_last[ux] = ut;
      if (ut && m_ctr[ux] < 3) m_ctr[ux] = m_ctr[ux] + 1;
      if (!ut && m_ctr[ux] > 0) m_ctr[ux] = m_ctr[ux] - 1;
    end
    if (cw) m_opc[cop] = cb;
  endtask

  task automatic req(input logic [2:0] md, input logic [PC_W-1:0] pc,
                     input logic [OP_W-1:0] op, input string tag);
    step(1'b1, md, pc, op, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    step(1'b0, 3'd0, '0, '0, 1'b1, pc, t, 1'b0, '0, 1'b0, "R9 idle");
  endtask

  task automatic cfg(input logic [OP_W-1:0] op, input logic b);
    step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b1, op, b, "R9 idle");
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && exp_v_q.size() > 0) begin
        logic  ev, et;
        string tg;
        ev = exp_v_q.pop_front();
        et = exp_t_q.pop_front();
        tg = tag_q.pop_front();
        check({tg, " valid"}, pred_valid_o, ev);
        if (ev) check({tg, " taken"}, pred_taken_o, et);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < ENT; i++) begin m_last[i] = 1'b0; m_ctr[i] = 1; end
    for (int i = 0; i < CODES; i++) m_opc[i] = 1'b0;
    rst_n = 1'b0; mode_i = '0; req_valid_i = 1'b0; req_pc_i = '0; req_op_i = '0;
    upd_valid_i = 1'b0; upd_pc_i = '0; upd_taken_i = 1'b0;
    cfg_we_i = 1'b0; cfg_op_i = '0; cfg_bit_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", pred_valid_o, 1'b0);
    check("R9 reset taken", pred_taken_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after reset valid", pred_valid_o, 1'b0);
    mon_on = 1'b1;

    // R6: fresh entries
    for (int p = 0; p < 8; p++) begin
      req(3'd4, PC_W'(p * 4), '0, "R6 hist init");
      req(3'd3, PC_W'(p * 4 + 1), '0, "R6 last init");
    end
    req(3'd2, '0, 4'd7, "R3 opcode reset");

    // R1, R2 with training alongside (R10)
    step(1'b1, 3'd0, 32'd40, '0, 1'b1, 32'd40, 1'b1, 1'b0, '0, 1'b0, "R1 never");
    step(1'b1, 3'd1, 32'd41, '0, 1'b1, 32'd40, 1'b1, 1'b0, '0, 1'b0, "R2 always");
    req(3'd0, 32'd40, '0, "R1 never after train");
    req(3'd1, 32'd99, '0, "R2 always untrained");
    req(3'd3, 32'd40, '0, "R10 last trained in never");
    req(3'd4, 32'd40, '0, "R10 hist trained in never");

    // R3 opcode bits
    cfg(4'd3, 1'b1); cfg(4'd9, 1'b1); cfg(4'd15, 1'b1);
    for (int o = 0; o < CODES; o++) req(3'd2, 32'd8, OP_W'(o), "R3 opcode");
    upd(32'd3, 1'b1);
    req(3'd2, 32'd3, 4'd3, "R3 update no effect");
    step(1'b1, 3'd2, '0, 4'd4, 1'b0, '0, 1'b0, 1'b1, 4'd4, 1'b1, "R8 cfg same cycle");
    req(3'd2, '0, 4'd4, "R3 after write");

    // R4 one-bit
    upd(32'd30, 1'b1); req(3'd3, 32'd30, '0, "R4 last taken");
    upd(32'd30, 1'b0); req(3'd3, 32'd30, '0, "R4 last not taken");
    upd(32'd30, 1'b1); upd(32'd30, 1'b1); req(3'd3, 32'd30, '0, "R4 last taken again");

    // R5 counter walk
    upd(32'd20, 1'b1); req(3'd4, 32'd20, '0, "R5 weak taken");
    upd(32'd20, 1'b0); req(3'd4, 32'd20, '0, "R5 weak not taken");
    for (int k = 0; k < 5; k++) upd(32'd20, 1'b1);
    req(3'd4, 32'd20, '0, "R5 saturate high");
    upd(32'd20, 1'b0); req(3'd4, 32'd20, '0, "R5 down from max");
    upd(32'd20, 1'b0); req(3'd4, 32'd20, '0, "R5 below threshold");
    for (int k = 0; k < 4; k++) upd(32'd20, 1'b0);
    upd(32'd20, 1'b1); req(3'd4, 32'd20, '0, "R5 up from min");
    upd(32'd20, 1'b1); req(3'd4, 32'd20, '0, "R5 threshold");

    // R7 aliasing
    upd(32'd5, 1'b1); upd(32'd5, 1'b1);
    req(3'd3, 32'd5 + 32'd64, '0, "R7 alias last");
    req(3'd4, 32'd5 + 32'd128, '0, "R7 alias hist");
    req(3'd3, 32'd6 + 32'd64, '0, "R7 neighbour");

    // R8 same-cycle update
    step(1'b1, 3'd4, 32'd50, '0, 1'b1, 32'd50, 1'b1, 1'b0, '0, 1'b0, "R8 hist old");
    req(3'd4, 32'd50, '0, "R8 hist new");
    step(1'b1, 3'd3, 32'd51, '0, 1'b1, 32'd51, 1'b1, 1'b0, '0, 1'b0, "R8 last old");
    req(3'd3, 32'd51, '0, "R8 last new");

    // R9 spare codes and gaps
    upd(32'd60, 1'b1); upd(32'd60, 1'b1);
    req(3'd5, 32'd60, 4'd3, "R9 code5");
    req(3'd6, 32'd60, 4'd3, "R9 code6");
    req(3'd7, 32'd60, 4'd3, "R9 code7");
    step(1'b0, 3'd1, '0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R9 idle gap");

    // mixed trace
    lfsr = 16'hACE1;
    for (int s = 0; s < 800; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[4:2], PC_W'(lfsr[12:5]), lfsr[15:12],
           lfsr[13], PC_W'({lfsr[3:0], lfsr[9:6]}), lfsr[11] ^ lfsr[14],
           (lfsr[15:13] == 3'b101), lfsr[8:5], lfsr[2], "R10 mixed trace");
    end

    repeat (4) step(1'b0, 3'd0, '0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, "R9 drain");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule